// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block is the host-side master for an 8-bit multiplexed NAND bus. A request carries a row address, a starting column and a byte count. The sequencer selects the device and issues the read opening code. It then shifts the column and row out over five address cycles and sends the confirm code. Next it waits for the device's ready/busy line to report ready. Finally it pulses read enable once per byte and hands each byte to a consumer over a valid/ready stream.

While a page is open, the consumer side can ask for a jump to another column of the same page. The sequencer sends the short column-change sequence and streams from the new column without opening the page again. Strobe widths, the settle delay after the confirm and the busy timeout are all counted in clock cycles and set by parameters. The ready/busy pin is asynchronous and passes through a two-stage synchronizer before use.

States: `S_IDLE`; `S_CMD_RD` (opening code); `S_ADDR` (five address cycles); `S_CMD_CONF` (confirm); `S_WAIT_RB` (settle and busy wait); `S_READ` (read strobes); and `S_JMP_CMD`, `S_JMP_ADDR`, `S_JMP_CONF` (column change). Transitions:
- `S_IDLE` to `S_CMD_RD` on an accepted request.
- Each bus-write state moves on when its write strobe completes.
- `S_ADDR` moves on after the last address byte.
- `S_WAIT_RB` goes to `S_READ` when the device is ready, or to `S_IDLE` on timeout.
- `S_READ` goes to `S_JMP_CMD` on an accepted jump, or to `S_IDLE` once the count is used up and the last byte has been taken.
- `S_JMP_CONF` returns to `S_READ`.

Top module: `nand_rd_seq`

## Requirements
- R1: `req_ready` is high exactly in idle, where chip enable is high. An accepted request produces these bus writes in this order: command 0x00; address bytes col[7:0], {4'b0000, col[11:8]}, row[7:0], row[15:8], row[23:16]; command 0x30.
- R2: Command writes have CLE=1 and ALE=0. Address writes have ALE=1 and CLE=0. Every write has CE low, RE high and the data bus driven. The value is taken on the rising edge of WE, which stays low for WE_LO cycles and then high for WE_HI cycles.
- R3: After the confirm write, no read strobe starts until at least WB_CYC cycles have passed and the synchronized ready/busy line is high.
- R4: Each read strobe holds RE low for RE_LO cycles and high for RE_HI cycles. The bus is sampled in the last low cycle. Bytes appear on `dout_data` in ascending column order, starting at the requested column.
- R5: A request delivers min(len, 2112 - col) bytes, or none when col is above 2111 or len is 0. The last column read is 2111. When the transfer ends, chip enable returns high and `req_ready` rises.
- R6: While `dout_valid` is high and `dout_ready` is low, no read strobe begins and `dout_data` holds its value. No byte is lost or repeated under any ready pattern.
- R7: A jump is accepted (`jmp_ready`) only in the read phase with no strobe in flight. It issues command 0x05, column bytes in the R1 layout and command 0xE0. Streaming then continues from `jmp_col` for `jmp_len` bytes, still capped at column 2111. A jump request in idle causes no bus activity.
- R8: If the device is not ready within TMO_CYC cycles of the confirm, `err_tmo` is set, chip enable is released and no byte is delivered. `err_tmo` clears when the next request is accepted.
- R9: Under reset, CE, WE and RE are high, `req_ready` is high, and `dout_valid` and `err_tmo` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Request accepted (idle) |
| req_row | input | 24 | Page row address |
| req_col | input | 12 | Starting column |
| req_len | input | 12 | Bytes to read |
| jmp_valid | input | 1 | Column jump request |
| jmp_ready | output | 1 | Column jump accepted |
| jmp_col | input | 12 | New column |
| jmp_len | input | 12 | Bytes to read from new column |
| dout_valid | output | 1 | Byte available |
| dout_ready | input | 1 | Consumer takes byte |
| dout_data | output | 8 | Byte read from page |
| err_tmo | output | 1 | Busy wait timed out |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable, active low |
| nand_re_n | output | 1 | Read enable, active low |
| nand_dq_o | output | 8 | Bus value driven to device |
| nand_dq_oe | output | 1 | Bus drive enable |
| nand_dq_i | input | 8 | Bus value from device |
| nand_rb | input | 1 | Ready/busy, high when ready |

## Verification
Random rows, starting columns, lengths and busy durations cover several things at once. Shifted or swapped address bytes show up as wrong data, and off-by-one column counting shows up as a wrong byte count. Directed starts at columns 2100, 2111 and 2200, and a zero length, separate the page-end clamp from the length limit. Three consumer patterns are used: always ready, randomly stalled, and held off. Together they separate correct back-pressure from dropped or duplicated bytes. Jumps mid-stream and near page end show whether the column change resumes at the right place, and a device that never becomes ready exercises the timeout path and its clearing.

// File: rtl/nrs_pkg.sv
package nrs_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_CMD_RD, S_ADDR, S_CMD_CONF, S_WAIT_RB,
        S_READ, S_JMP_CMD, S_JMP_ADDR, S_JMP_CONF
    } seq_state_t;

    typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} strobe_ph_t;

    localparam logic [7:0] OP_OPEN     = 8'h00;
    localparam logic [7:0] OP_CONFIRM  = 8'h30;
    localparam logic [7:0] OP_JUMP     = 8'h05;
    localparam logic [7:0] OP_JUMP_GO  = 8'hE0;
    localparam int         JUMP_ADDR_N = 2;
endpackage

// File: rtl/nrs_sync2.sv
module nrs_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic s1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            q  <= 1'b0;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/nrs_strobe.sv
module nrs_strobe import nrs_pkg::*; #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] lo_cyc,
    input  logic [CW-1:0] hi_cyc,
    output logic          busy,
    output logic          low,
    output logic          last_low,
    output logic          done
);
    strobe_ph_t    ph;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: if (start) begin
                    ph  <= PH_LOW;
                    cnt <= lo_cyc - CW'(1);
                end
                PH_LOW: if (cnt == '0) begin
                    ph  <= PH_HIGH;
                    cnt <= hi_cyc - CW'(1);
                end else begin
                    cnt <= cnt - CW'(1);
                end
                PH_HIGH: if (cnt == '0) begin
                    ph <= PH_IDLE;
                end else begin
                    cnt <= cnt - CW'(1);
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        busy     = (ph != PH_IDLE);
        low      = (ph == PH_LOW);
        last_low = (ph == PH_LOW) && (cnt == '0);
        done     = (ph == PH_HIGH) && (cnt == '0);
    end
endmodule

// File: rtl/nand_rd_seq.sv
module nand_rd_seq import nrs_pkg::*; #(
    parameter int COL_W      = 12,
    parameter int ROW_W      = 24,
    parameter int LEN_W      = 12,
    parameter int PAGE_BYTES = 2112,
    parameter int WE_LO      = 2,
    parameter int WE_HI      = 2,
    parameter int RE_LO      = 2,
    parameter int RE_HI      = 1,
    parameter int WB_CYC     = 4,
    parameter int TMO_CYC    = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [LEN_W-1:0] req_len,
    input  logic             jmp_valid,
    output logic             jmp_ready,
    input  logic [COL_W-1:0] jmp_col,
    input  logic [LEN_W-1:0] jmp_len,
    output logic             dout_valid,
    input  logic             dout_ready,
    output logic [7:0]       dout_data,
    output logic             err_tmo,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dq_o,
    output logic             nand_dq_oe,
    input  logic [7:0]       nand_dq_i,
    input  logic             nand_rb
);
    localparam int ROW_BYTES = ROW_W / 8;
    localparam int ADDR_CYC  = 2 + ROW_BYTES;
    localparam int AIW       = $clog2(ADDR_CYC);
    localparam int TMAX_A    = (WE_LO > WE_HI) ? WE_LO : WE_HI;
    localparam int TMAX_B    = (RE_LO > RE_HI) ? RE_LO : RE_HI;
    localparam int TMAX      = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
    localparam int TW        = $clog2(TMAX + 1);
    localparam int WTW       = $clog2(TMO_CYC + 1);
    localparam logic [COL_W-1:0] LAST_C   = COL_W'(PAGE_BYTES - 1);
    localparam logic [AIW-1:0]   ADDR_END = AIW'(ADDR_CYC - 1);
    localparam logic [AIW-1:0]   JMP_END  = AIW'(JUMP_ADDR_N - 1);

    seq_state_t       state, nxt;
    logic [AIW-1:0]   aidx;
    logic [COL_W-1:0] col_q;
    logic [ROW_W-1:0] row_q;
    logic [LEN_W-1:0] rem_q;
    logic [WTW-1:0]   wcnt;
    logic             err_q;
    logic             rb_s;
    logic [7:0]       addr_bytes [ADDR_CYC];

    logic             t_start, t_busy, t_low, t_last_low, t_done;
    logic [TW-1:0]    t_lo, t_hi;
    logic             wr_state, in_read, read_end, can_pulse, jmp_take, dev_ready;

    nrs_sync2 u_rb_sync (.clk(clk), .rst_n(rst_n), .d(nand_rb), .q(rb_s));

    nrs_strobe #(.CW(TW)) u_strobe (
        .clk(clk), .rst_n(rst_n), .start(t_start), .lo_cyc(t_lo), .hi_cyc(t_hi),
        .busy(t_busy), .low(t_low), .last_low(t_last_low), .done(t_done)
    );

    assign addr_bytes[0] = col_q[7:0];
    assign addr_bytes[1] = 8'(col_q >> 8);
    for (genvar g = 0; g < ROW_BYTES; g++) begin : g_row_byte
        assign addr_bytes[2+g] = row_q[8*g +: 8];
    end

    always_comb begin
        wr_state  = (state == S_CMD_RD) || (state == S_ADDR) || (state == S_CMD_CONF) ||
                    (state == S_JMP_CMD) || (state == S_JMP_ADDR) || (state == S_JMP_CONF);
        in_read   = (state == S_READ);
        read_end  = (rem_q == '0) || (col_q > LAST_C);
        jmp_ready = in_read && !t_busy;
        jmp_take  = jmp_ready && jmp_valid;
        can_pulse = in_read && !t_busy && !jmp_valid && !read_end &&
                    (!dout_valid || dout_ready);
        t_start   = (wr_state && !t_busy) || can_pulse;
        t_lo      = in_read ? TW'(RE_LO) : TW'(WE_LO);
        t_hi      = in_read ? TW'(RE_HI) : TW'(WE_HI);
        dev_ready = (wcnt >= WTW'(WB_CYC)) && rb_s;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (req_valid) nxt = S_CMD_RD;
            S_CMD_RD:   if (t_done) nxt = S_ADDR;
            S_ADDR:     if (t_done && aidx == ADDR_END) nxt = S_CMD_CONF;
            S_CMD_CONF: if (t_done) nxt = S_WAIT_RB;
            S_WAIT_RB: begin
                if (dev_ready) nxt = S_READ;
                else if (wcnt == WTW'(TMO_CYC)) nxt = S_IDLE;
            end
            S_READ: begin
                if (jmp_take) nxt = S_JMP_CMD;
                else if (!t_busy && read_end && !dout_valid) nxt = S_IDLE;
            end
            S_JMP_CMD:  if (t_done) nxt = S_JMP_ADDR;
            S_JMP_ADDR: if (t_done && aidx == JMP_END) nxt = S_JMP_CONF;
            S_JMP_CONF: if (t_done) nxt = S_READ;
            default:    nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aidx       <= '0;
            col_q      <= '0;
            row_q      <= '0;
            rem_q      <= '0;
            wcnt       <= '0;
            err_q      <= 1'b0;
            dout_valid <= 1'b0;
            dout_data  <= '0;
        end else begin
            if (state == S_IDLE && req_valid) begin
                row_q <= req_row;
                col_q <= req_col;
                rem_q <= req_len;
                err_q <= 1'b0;
            end
            if ((state == S_ADDR || state == S_JMP_ADDR) && t_done) aidx <= aidx + AIW'(1);
            else if (state != S_ADDR && state != S_JMP_ADDR)       aidx <= '0;
            if (state == S_WAIT_RB) begin
                wcnt <= wcnt + WTW'(1);
                if (!dev_ready && wcnt == WTW'(TMO_CYC)) err_q <= 1'b1;
            end else begin
                wcnt <= '0;
            end
            if (jmp_take) begin
                col_q <= jmp_col;
                rem_q <= jmp_len;
            end
            if (in_read && t_last_low) begin
                dout_data  <= nand_dq_i;
                dout_valid <= 1'b1;
                col_q      <= col_q + COL_W'(1);
                rem_q      <= rem_q - LEN_W'(1);
            end else if (dout_valid && dout_ready) begin
                dout_valid <= 1'b0;
            end
        end
    end

    // bus outputs
    always_comb begin
        req_ready  = (state == S_IDLE);
        err_tmo    = err_q;
        nand_ce_n  = (state == S_IDLE);
        nand_cle   = (state == S_CMD_RD) || (state == S_CMD_CONF) ||
                     (state == S_JMP_CMD) || (state == S_JMP_CONF);
        nand_ale   = (state == S_ADDR) || (state == S_JMP_ADDR);
        nand_we_n  = !(wr_state && t_low);
        nand_re_n  = !(in_read && t_low);
        nand_dq_oe = wr_state;
        unique case (state)
            S_CMD_CONF:             nand_dq_o = OP_CONFIRM;
            S_JMP_CMD:              nand_dq_o = OP_JUMP;
            S_JMP_CONF:             nand_dq_o = OP_JUMP_GO;
            S_ADDR, S_JMP_ADDR:     nand_dq_o = addr_bytes[aidx];
            default:                nand_dq_o = OP_OPEN;
        endcase
    end
endmodule

// File: rtl/nrs_chk.sv
module nrs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       jmp_ready,
    input logic       dout_valid,
    input logic       dout_ready,
    input logic [7:0] dout_data,
    input logic       err_tmo,
    input logic       nand_ce_n,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic       nand_dq_oe,
    input logic       nand_rb
);
    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> nand_ce_n); // R1
    AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale)); // R2
    AST_WE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> (nand_dq_oe && nand_re_n && !nand_ce_n)); // R2
    AST_RE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_re_n) |-> nand_rb); // R3
    AST_NO_RE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nand_re_n) |-> $past(!dout_valid || dout_ready)); // R6
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && !dout_ready) |=> (dout_valid && $stable(dout_data))); // R6
    AST_JMP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_ready |-> (nand_re_n && nand_we_n)); // R7
    AST_TMO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_tmo) |-> (nand_ce_n && !dout_valid)); // R8
endmodule

bind nand_rd_seq nrs_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .jmp_ready(jmp_ready),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data),
    .err_tmo(err_tmo), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_oe(nand_dq_oe), .nand_rb(nand_rb)
);

// File: tb/sim_nand_rd_seq.sv
`timescale 1ns/1ps
module sim_nand_rd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_row = '0;
    logic [11:0] req_col = '0;
    logic [11:0] req_len = '0;
    logic        jmp_valid = 1'b0;
    logic        jmp_ready;
    logic [11:0] jmp_col = '0;
    logic [11:0] jmp_len = '0;
    logic        dout_valid;
    logic        dout_ready = 1'b0;
    logic [7:0]  dout_data;
    logic        err_tmo;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_o;
    logic [7:0]  nand_dq_i = '0;
    logic        nand_rb;

    always #2.5 clk = ~clk;

    nand_rd_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_row(req_row), .req_col(req_col), .req_len(req_len),
        .jmp_valid(jmp_valid), .jmp_ready(jmp_ready), .jmp_col(jmp_col), .jmp_len(jmp_len),
        .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data),
        .err_tmo(err_tmo), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o),
        .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i), .nand_rb(nand_rb)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pb(input logic [23:0] r, input int c);
        logic [31:0] h;
        h = (32'(r) * 32'd2654435761) ^ (32'(c) * 32'd40503) ^ 32'h5A5A1234;
        return h[31:24] ^ h[15:8] ^ h[7:0];
    endfunction

    function automatic int expn(input int c, input int l);
        if (c > 2111) return 0;
        return (l < 2112 - c) ? l : 2112 - c;
    endfunction

    // device model
    int          busy_len = 10;
    bit          stuck = 1'b0;
    int          busy_cnt = 0;
    logic        we_q = 1'b1;
    logic [7:0]  ab [5];
    int          an = 0;
    logic [23:0] m_row = '0;
    int          m_scol = 0;
    int          gen = 0;
    int          seen_gen = 0;
    int          ptr = 0;
    int          proto_err = 0;
    int          re_viol = 0;
    int          re_falls = 0;
    logic [7:0]  log_b [$];
    logic        log_c [$];
    logic [7:0]  got [$];
    int          ready_mode = 0;

    assign nand_rb = (busy_cnt == 0);

    always @(negedge clk) begin
        if (!rst_n) begin
            we_q = 1'b1;
            busy_cnt = 0;
            an = 0;
        end else begin
            if (busy_cnt > 0 && !stuck) busy_cnt--;
            if (nand_we_n && !we_q) begin
                if (nand_ce_n || (nand_cle == nand_ale) || !nand_re_n || !nand_dq_oe) proto_err++;
                log_b.push_back(nand_dq_o);
                log_c.push_back(nand_cle);
                if (nand_cle) begin
                    if (nand_dq_o == 8'h30) begin
                        m_row = {ab[4], ab[3], ab[2]};
                        m_scol = int'({ab[1][3:0], ab[0]});
                        gen++;
                        busy_cnt = busy_len;
                    end else if (nand_dq_o == 8'hE0) begin
                        m_scol = int'({ab[1][3:0], ab[0]});
                        gen++;
                    end
                    an = 0;
                end else begin
                    if (an < 5) ab[an] = nand_dq_o;
                    an++;
                end
            end
            we_q = nand_we_n;
        end
    end

    always @(negedge nand_re_n) begin
        if (rst_n) begin
            re_falls++;
            if (!nand_rb) re_viol++;
            if (seen_gen != gen) begin
                ptr = m_scol;
                seen_gen = gen;
            end
            nand_dq_i = pb(m_row, ptr);
            ptr++;
        end
    end

    // consumer: 0 random, 1 always ready, 2 never ready
    always @(negedge clk) begin
        if (ready_mode == 1)      dout_ready = 1'b1;
        else if (ready_mode == 2) dout_ready = 1'b0;
        else                      dout_ready = ($urandom % 4) != 0;
        if (rst_n && dout_valid && dout_ready) got.push_back(dout_data);
    end

    task automatic start_req(input logic [23:0] r, input int c, input int l, input int bl);
        log_b.delete();
        log_c.delete();
        got.delete();
        re_falls = 0;
        busy_len = bl;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_row = r;
        req_col = 12'(c);
        req_len = 12'(l);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_open(input logic [23:0] r, input int c);
        logic [7:0] eb [7];
        logic       ec [7];
        eb = '{8'h00, 8'(c), 8'(c >> 8), r[7:0], r[15:8], r[23:16], 8'h30};
        ec = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
        chk(log_b.size() >= 7, "R1 bus write count", log_b.size(), 7);
        if (log_b.size() >= 7) begin
            for (int i = 0; i < 7; i++) begin
                chk(log_b[i] == eb[i], "R1 open sequence byte", log_b[i], eb[i]);
                chk(log_c[i] == ec[i], "R2 cmd/addr latch select", log_c[i], ec[i]);
            end
        end
        chk(proto_err == 0, "R2 write cycle qualifiers", proto_err, 0);
    endtask

    task automatic check_data(input logic [23:0] r, input int c, input int l);
        int n;
        n = expn(c, l);
        chk(got.size() == n, "R5 byte count", got.size(), n);
        for (int i = 0; i < got.size() && i < n; i++)
            chk(got[i] == pb(r, c + i), "R4 byte value in column order", got[i], pb(r, c + i));
        chk(re_viol == 0, "R3 strobe while busy", re_viol, 0);
        chk(nand_ce_n == 1'b1, "R5 deselect at end", nand_ce_n, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int tl;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(nand_ce_n == 1'b1 && nand_we_n == 1'b1 && nand_re_n == 1'b1, "R9 strobes idle", {nand_ce_n, nand_we_n, nand_re_n}, 7);
        chk(req_ready == 1'b1, "R9 ready in reset", req_ready, 1);
        chk(dout_valid == 1'b0 && err_tmo == 1'b0, "R9 outputs cleared", {dout_valid, err_tmo}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7: jump request in idle does nothing
        jmp_valid = 1'b1;
        jmp_col = 12'd7;
        repeat (10) begin
            @(negedge clk);
            chk(jmp_ready == 1'b0, "R7 jump refused in idle", jmp_ready, 0);
        end
        jmp_valid = 1'b0;
        chk(log_b.size() == 0, "R7 no bus write from idle jump", log_b.size(), 0);

        // directed corner cases
        ready_mode = 1;
        start_req(24'h123456, 100, 16, 20);
        wait_idle();
        check_open(24'h123456, 100);
        check_data(24'h123456, 100, 16);

        start_req(24'hA5C3F0, 2100, 50, 8);
        wait_idle();
        check_open(24'hA5C3F0, 2100);
        check_data(24'hA5C3F0, 2100, 50);

        start_req(24'h00FF01, 2111, 5, 8);
        wait_idle();
        check_data(24'h00FF01, 2111, 5);

        start_req(24'h000777, 2200, 5, 8);
        wait_idle();
        check_open(24'h000777, 2200);
        check_data(24'h000777, 2200, 5);

        start_req(24'h010203, 40, 0, 8);
        wait_idle();
        check_data(24'h010203, 40, 0);

        // R6 consumer held off
        ready_mode = 2;
        start_req(24'h3C3C3C, 500, 10, 6);
        repeat (200) @(negedge clk);
        chk(re_falls == 1, "R6 strobes while stalled", re_falls, 1);
        chk(dout_valid == 1'b1, "R6 byte held while stalled", dout_valid, 1);
        ready_mode = 1;
        wait_idle();
        check_data(24'h3C3C3C, 500, 10);

        // R7 mid-page jump
        start_req(24'h4D2E11, 100, 300, 12);
        while (got.size() < 5) @(negedge clk);
        jmp_col = 12'd1500;
        jmp_len = 12'd20;
        jmp_valid = 1'b1;
        while (!jmp_ready) @(negedge clk);
        @(negedge clk);
        jmp_valid = 1'b0;
        wait_idle();
        chk(log_b.size() == 11, "R7 jump write count", log_b.size(), 11);
        if (log_b.size() == 11) begin
            chk(log_b[7] == 8'h05 && log_c[7], "R7 jump command", log_b[7], 8'h05);
            chk(log_b[8] == 8'hDC && !log_c[8], "R7 jump col low", log_b[8], 8'hDC);
            chk(log_b[9] == 8'h05 && !log_c[9], "R7 jump col high", log_b[9], 8'h05);
            chk(log_b[10] == 8'hE0 && log_c[10], "R7 jump confirm", log_b[10], 8'hE0);
        end
        tl = got.size() - 20;
        chk(tl >= 5, "R7 bytes before jump", tl, 5);
        for (int i = 0; i < got.size(); i++) begin
            if (i < tl) chk(got[i] == pb(24'h4D2E11, 100 + i), "R7 pre-jump byte", got[i], pb(24'h4D2E11, 100 + i));
            else        chk(got[i] == pb(24'h4D2E11, 1500 + i - tl), "R7 post-jump byte", got[i], pb(24'h4D2E11, 1500 + i - tl));
        end

        // R7 jump clamped at page end
        start_req(24'h777000, 10, 200, 9);
        while (got.size() < 3) @(negedge clk);
        jmp_col = 12'd2100;
        jmp_len = 12'd50;
        jmp_valid = 1'b1;
        while (!jmp_ready) @(negedge clk);
        @(negedge clk);
        jmp_valid = 1'b0;
        wait_idle();
        tl = got.size() - 12;
        chk(tl >= 3, "R7 clamped jump total", got.size(), tl + 12);
        if (got.size() >= 12)
            chk(got[got.size()-1] == pb(24'h777000, 2111), "R7 last byte at column 2111", got[got.size()-1], pb(24'h777000, 2111));

        // R8 busy timeout then recovery
        stuck = 1'b1;
        start_req(24'h0BAD00, 0, 8, 5);
        wait_idle();
        chk(err_tmo == 1'b1, "R8 timeout flag", err_tmo, 1);
        chk(got.size() == 0, "R8 no data on timeout", got.size(), 0);
        chk(re_falls == 0, "R8 no strobe on timeout", re_falls, 0);
        chk(log_b.size() == 7, "R8 open sequence only", log_b.size(), 7);
        stuck = 1'b0;
        start_req(24'h0B0B0B, 60, 4, 5);
        wait_idle();
        chk(err_tmo == 1'b0, "R8 flag cleared by new request", err_tmo, 0);
        check_data(24'h0B0B0B, 60, 4);

        // random traffic with random back-pressure
        ready_mode = 0;
        for (int t = 0; t < 25; t++) begin
            logic [23:0] r;
            int c, l, bl;
            r = 24'($urandom);
            c = ($urandom % 8 == 0) ? 2090 + int'($urandom % 30) : int'($urandom % 2200);
            l = int'($urandom % 48);
            bl = 5 + int'($urandom % 60);
            start_req(r, c, l, bl);
            wait_idle();
            check_open(r, c);
            check_data(r, c, l);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule